// File: doc/BRIEF.md
# Master clock source selector with prescaler

This block derives the master clock of a chip from one of four candidate sources: a slow clock, the main oscillator clock, a first PLL and a USB PLL. Each source reaches the block as a one-cycle edge pulse on a fast reference clock, so all selection and division happen in one clock domain. Software picks a source and a division ratio with a single configuration write. The block then produces one master-clock pulse per divided period.

Every configuration write drops the ready flag. The request is held pending until it can be applied. A request for a PLL source stays pending while that PLL reports no lock, and the previous source and ratio keep running in the meantime. Once the request is applied, the divider restarts from zero. The ready flag comes back only after two complete periods of the new master clock have been produced.

Top module: `mck_gen`

## Requirements
- R1: During reset, and right after it, the active source is 0 (slow clock), the active division code is 0, `mck_ready` is 0 and `mck_tick` is 0.
- R2: Division codes 0 to 6 give ratios 1, 2, 4, 8, 16, 32 and 64. After every ratio-th selected-source pulse, `mck_tick` is high for one cycle, in the cycle after that source pulse.
- R3: Division code 7 gives a ratio of 3, with the same pulse timing as R2.
- R4: In the cycle after any cycle with `cfg_we` high, `mck_ready` is 0.
- R5: `mck_ready` is 1 only when no request is pending and two `mck_tick` pulses have occurred since the last apply. It rises in the cycle after the second such pulse.
- R6: Source codes are 0 slow, 1 main, 2 first PLL, 3 USB PLL. A request for source 2 waits for `pll_lock[0]`, and a request for source 3 waits for `pll_lock[1]`. While it waits, `act_src`, `act_div` and the `mck_tick` pattern follow the old configuration, and `mck_ready` stays 0.
- R7: A request is applied at the first clock edge at which it is pending, its source is usable and `cfg_we` is low. `act_src` and `act_div` take the requested values from that edge onward. With no blocking condition, this is two cycles after the write cycle.
- R8: At an apply, the divider restarts from zero. `mck_tick` is 0 in the cycle after the apply, and a source pulse that arrives in the apply cycle is discarded.
- R9: A write while a request is pending replaces that request. A write in a cycle where an apply would otherwise happen postpones the apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, faster than every source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Requested source code |
| cfg_div | input | 3 | Requested division code |
| src_tick | input | 4 | Edge pulse of each source, indexed by source code |
| pll_lock | input | 2 | Lock status: bit 0 first PLL, bit 1 USB PLL |
| mck_tick | output | 1 | One pulse per master-clock period |
| mck_ready | output | 1 | Master clock established |
| act_src | output | 2 | Source currently in use |
| act_div | output | 3 | Division code currently in use |

## Verification
A configuration write can land in the same cycle as the apply of an earlier request, or in the same cycle as the second settling pulse that would raise ready. Both cases are provoked by a sweep that issues a second write at every offset from zero to two dozen cycles after a first one, across different sources and ratios. A behavioural model in the bench tracks the pending request, the divider phase and the settle count. It is compared with the outputs on every cycle, so a wrong priority between the write and the apply, or a ready flag that escapes on the colliding pulse, shows up in the cycle where it happens.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int SRC_N    = 4;
  localparam int SRC_W    = $clog2(SRC_N);
  localparam int PLL_N    = 2;
  localparam int DIV_W    = 3;
  localparam int MAX_LOG  = 6;
  localparam int RAT_W    = MAX_LOG + 1;
  localparam int CNT_W    = MAX_LOG;
  localparam int SETTLE_N = 2;
  localparam int SET_W    = $clog2(SETTLE_N + 1);

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLLA = 2'd2,
    SRC_UPLL = 2'd3
  } src_e;

  // Division code to ratio: 0..6 are powers of two, 7 is the odd ratio 3.
  function automatic logic [RAT_W-1:0] div_ratio(input logic [DIV_W-1:0] code);
    if (code == 3'd7) return RAT_W'(3);
    return RAT_W'(1) << code;
  endfunction

  // Sources in the upper half are PLLs and need their lock flag.
  function automatic logic src_usable(input logic [SRC_W-1:0] src,
                                      input logic [PLL_N-1:0] lock);
    if (!src[SRC_W-1]) return 1'b1;
    return lock[src[0]];
  endfunction
endpackage

// File: rtl/mck_cfg_ctrl.sv
module mck_cfg_ctrl
  import mck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [PLL_N-1:0] pll_lock,
  output logic [SRC_W-1:0] act_src,
  output logic [DIV_W-1:0] act_div,
  output logic             pending,
  output logic             apply_evt
);
  logic [SRC_W-1:0] req_src;
  logic [DIV_W-1:0] req_div;

  assign apply_evt = pending && !cfg_we && src_usable(req_src, pll_lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      req_src <= '0;
      req_div <= '0;
      act_src <= SRC_SLOW;
      act_div <= '0;
    end else begin
      if (cfg_we) begin
        pending <= 1'b1;
        req_src <= cfg_src;
        req_div <= cfg_div;
      end else if (apply_evt) begin
        pending <= 1'b0;
      end
      if (apply_evt) begin
        act_src <= req_src;
        act_div <= req_div;
      end
    end
  end
endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler
  import mck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             sel_tick,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick_o
);
  logic [CNT_W-1:0] phase;
  logic [RAT_W-1:0] ratio;
  logic             wrap;

  assign ratio = div_ratio(div_code);
  assign wrap  = ({1'b0, phase} == ratio - RAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      tick_o <= 1'b0;
    end else if (restart) begin
      phase  <= '0;
      tick_o <= 1'b0;
    end else if (sel_tick) begin
      phase  <= wrap ? '0 : phase + CNT_W'(1);
      tick_o <= wrap;
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mck_ready_track.sv
module mck_ready_track
  import mck_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pending,
  input  logic tick_i,
  output logic ready
);
  logic [SET_W-1:0] seen;

  assign ready = !pending && (seen == SET_W'(SETTLE_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen <= '0;
    else if (restart)
      seen <= '0;
    else if (tick_i && seen < SET_W'(SETTLE_N))
      seen <= seen + SET_W'(1);
  end
endmodule

// File: rtl/mck_gen.sv
module mck_gen
  import mck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [SRC_N-1:0] src_tick,
  input  logic [PLL_N-1:0] pll_lock,
  output logic             mck_tick,
  output logic             mck_ready,
  output logic [SRC_W-1:0] act_src,
  output logic [DIV_W-1:0] act_div
);
  logic pending;
  logic apply_evt;
  logic sel_tick;

  assign sel_tick = src_tick[act_src];

  mck_cfg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_div(cfg_div), .pll_lock(pll_lock), .act_src(act_src),
    .act_div(act_div), .pending(pending), .apply_evt(apply_evt)
  );

  mck_prescaler u_pres (
    .clk(clk), .rst_n(rst_n), .restart(apply_evt), .sel_tick(sel_tick),
    .div_code(act_div), .tick_o(mck_tick)
  );

  mck_ready_track u_rdy (
    .clk(clk), .rst_n(rst_n), .restart(apply_evt), .pending(pending),
    .tick_i(mck_tick), .ready(mck_ready)
  );
endmodule

// File: rtl/mck_gen_chk.sv
module mck_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [1:0] pll_lock,
  input logic [1:0] act_src,
  input logic       mck_tick,
  input logic       mck_ready,
  input logic       pending,
  input logic       apply_evt
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!mck_ready && !mck_tick && act_src == 2'd0);
    end
  end

  assert_write_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !mck_ready);

  assert_ready_only_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mck_ready |-> !pending);

  assert_ready_follows_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mck_ready) |-> $past(mck_tick));

  assert_pll_locked_on_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_src) && act_src[1]) |-> $past(pll_lock[act_src[0]]));

  assert_restart_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> !mck_tick);

  assert_write_defers_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !apply_evt);
endmodule

bind mck_gen mck_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .pll_lock(pll_lock),
  .act_src(act_src), .mck_tick(mck_tick), .mck_ready(mck_ready),
  .pending(pending), .apply_evt(apply_evt)
);

// File: tb/sim_mck_gen.sv
module sim_mck_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_src = '0;
  logic [2:0] cfg_div = '0;
  logic [3:0] src_tick = '0;
  logic [1:0] pll_lock = 2'b11;
  logic       mck_tick, mck_ready;
  logic [1:0] act_src;
  logic [2:0] act_div;

  int tests = 0, fails = 0, cyc = 0, kk = 0;
  bit finished = 0;
  int period [4] = '{9, 2, 1, 3};

  // reference model state
  int m_src, m_div, p_src, p_div, m_cnt, m_settle;
  bit m_pend, m_tick, r_ok, r_app, r_old;

  always #5 clk = ~clk;

  mck_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_div(cfg_div), .src_tick(src_tick), .pll_lock(pll_lock),
    .mck_tick(mck_tick), .mck_ready(mck_ready), .act_src(act_src),
    .act_div(act_div)
  );

  function automatic int ref_ratio(int code);
    return (code == 7) ? 3 : (2 ** code);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_div = 0; p_src = 0; p_div = 0;
      m_cnt = 0; m_settle = 0; m_pend = 0; m_tick = 0;
    end else begin
      r_ok  = (p_src < 2) || pll_lock[p_src - 2];
      r_app = m_pend && r_ok && !cfg_we;
      r_old = m_tick;
      if (r_app) begin
        m_src = p_src; m_div = p_div; m_cnt = 0; m_tick = 0; m_settle = 0;
      end else begin
        if (r_old && m_settle < 2) m_settle++;
        if (src_tick[m_src]) begin
          if (m_cnt + 1 == ref_ratio(m_div)) begin m_cnt = 0; m_tick = 1; end
          else begin m_cnt++; m_tick = 0; end
        end else m_tick = 0;
      end
      if (cfg_we) begin m_pend = 1; p_src = cfg_src; p_div = cfg_div; end
      else if (r_app) m_pend = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      chk("R2 R3 R8 mck_tick", mck_tick, m_tick);
      chk("R4 R5 mck_ready", mck_ready, (!m_pend && m_settle == 2));
      chk("R6 R7 act_src", act_src, m_src);
      chk("R6 R7 act_div", act_div, m_div);
    end
    kk++;
    for (int i = 0; i < 4; i++) src_tick[i] = (kk % period[i]) == 0;
    cfg_we = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic wr(int s, int d);
    step();
    cfg_we = 1'b1; cfg_src = 2'(s); cfg_div = 3'(d);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_up();
    end
  end

  initial begin
    run(4);
    @(negedge clk);
    // R1: reset values
    chk("R1 act_src", act_src, 0);
    chk("R1 act_div", act_div, 0);
    chk("R1 mck_ready", mck_ready, 0);
    chk("R1 mck_tick", mck_tick, 0);
    rst_n = 1'b1;
    run(40);
    // R2 R3: every ratio on the main clock, then on the first PLL
    for (int d = 0; d < 8; d++) begin wr(1, d); run(4 * ref_ratio(d) + 20); end
    for (int d = 0; d < 8; d++) begin wr(2, d); run(3 * ref_ratio(d) + 20); end
    // R6: USB PLL unlocked, old clock must keep running
    pll_lock = 2'b01;
    wr(3, 2); run(60);
    pll_lock = 2'b11; run(60);
    pll_lock = 2'b10;
    wr(2, 7); run(45);
    pll_lock = 2'b11; run(40);
    // R2: slowest ratio on the slow clock
    wr(0, 6); run(1300);
    // R9: second write at every offset, colliding with apply and settling
    for (int off = 0; off < 25; off++) begin
      wr(1 + (off % 3), off % 8);
      run(off);
      wr(3 - (off % 2), (off + 3) % 8);
      run(45);
    end
    // R9: back-to-back writes replace the pending request
    wr(0, 1); wr(1, 7); run(40);
    finish_up();
  end
endmodule